// File: doc/BRIEF.md
# ATA Device Probe and Soft-Reset Sequencer

This block runs the bring-up sequence of a parallel ATA channel that can carry two devices. It probes each device in turn. The probe selects the device, writes alternating bit patterns into two task-file registers and reads them back. The block then pulses the soft-reset bit of the device-control register. After the reset it waits for the devices to leave the busy state and re-selects them in a fixed order. All register traffic goes out as single operations to an external PIO cycle engine, using a level request and a one-cycle completion.

Delays come from an internal free-running cycle timer. The reset pulse settle time and the pause between device-1 register checks are build-time cycle counts. The readiness deadline is a per-run input, so software can set the bus timeout without a rebuild. The result is a two-bit presence mask and a timeout flag. Both are held until the next start.

Top module: `ata_probe_reset`

## Requirements
- R1: After reset, `busy`, `done`, `timeout`, `pio_req` and both `present` bits are 0.
- R2: A device select is a write to register code 0x6 with data 0xA0 for device 0 and 0xB0 for device 1. No other value is ever written to code 0x6.
- R3: The probe of one device is a fixed series of nine operations. It opens with a select. It then makes six writes that alternate between code 0x2 (sector count) and code 0x3 (LBA low), with data 0x55/0xAA, then 0xAA/0x55, then 0x55/0xAA. It closes with a read of code 0x2 and a read of code 0x3.
- R4: A device's presence bit is set only if the sector count read returns 0x55 and the LBA low read returns 0xAA. The mask is held unchanged while the block is idle.
- R5: Device 1 is probed only if `slave_possible` was high at start. After probing, device 0 is selected again.
- R6: Soft reset is three writes to code 0xE. The first and last carry `ctl_normal`. The middle one carries `ctl_normal` with bit 2 set. Successive writes are spaced by at least SRST_CYCLES clock cycles.
- R7: Each readiness wait reads status (code 0x7) until bit 7 is 0. A status of 0xFF also ends the wait and clears the presence bit of the device being waited on: device 0 after the reset, device 1 in the second wait.
- R8: If a status read shows bit 7 set and at least `deadline_cycles` cycles have passed since the wait began, the block sets `timeout`, ends the run and issues no further operation.
- R9: When device 1 is present, the block selects it and reads code 0x2 then code 0x3. It makes at most two such attempts and stops early if both reads return 0x01. The attempts are at least BREATH_CYCLES apart. The block then waits for readiness again.
- R10: The run ends with three selects: device 0 always, then device 1 if present, then device 0 if present.
- R11: `pio_req` stays high, with stable `pio_write`, `pio_reg` and `pio_wdata`, until `pio_done`. It drops in the cycle after `pio_done`.
- R12: `done` is a one-cycle pulse at the end of a run, when `busy` falls. `start`, `slave_possible`, `ctl_normal` and `deadline_cycles` are ignored while a run is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (sampled when idle) |
| slave_possible | input | 1 | Allow probing of device 1 |
| ctl_normal | input | 8 | Normal device-control byte |
| deadline_cycles | input | TW | Readiness deadline in clock cycles |
| pio_req | output | 1 | Operation request to the PIO engine |
| pio_write | output | 1 | 1 = write, 0 = read |
| pio_reg | output | 4 | Register code (0x2, 0x3, 0x6, 0x7, 0xE) |
| pio_wdata | output | 8 | Write data |
| pio_done | input | 1 | One-cycle completion from the PIO engine |
| pio_rdata | input | 8 | Read data, valid with `pio_done` |
| busy | output | 1 | Run in progress |
| done | output | 1 | End-of-run pulse |
| present | output | 2 | Device presence mask, bit n = device n |
| timeout | output | 1 | Readiness deadline expired |

## Verification
The embedded assertions check the handshake rules on every cycle: a request is held stable and then released, and only the two select codes are ever written. They also check that control writes differ from the normal byte only in the reset bit, that `done` is a single pulse, and that the presence mask and the timeout flag change only at the edges of a run. The exact order of operations depends on the read data the devices return, and only the scenarios can show it. So can the spacing of the reset and pause delays, the 0xFF and deadline outcomes, and the early exit from the device-1 register check. The scenarios cover one and two devices, a missing master, a failed pattern readback, a device that never clears busy, and a start pulse issued mid-run.

// File: rtl/ata_probe_pkg.sv
package ata_probe_pkg;
  localparam int REG_W = 4;

  // Register codes presented to the PIO engine
  localparam logic [REG_W-1:0] REG_NSECT = 4'h2;
  localparam logic [REG_W-1:0] REG_LBAL  = 4'h3;
  localparam logic [REG_W-1:0] REG_DEV   = 4'h6;
  localparam logic [REG_W-1:0] REG_STAT  = 4'h7;
  localparam logic [REG_W-1:0] REG_CTL   = 4'hE;

  localparam logic [7:0] DEV_SEL_BASE = 8'hA0;
  localparam logic [7:0] DEV1_MASK    = 8'h10;
  localparam logic [7:0] SRST_MASK    = 8'h04;
  localparam logic [7:0] PAT_A        = 8'h55;
  localparam logic [7:0] PAT_B        = 8'hAA;
  localparam logic [7:0] STAT_FLOAT   = 8'hFF;
  localparam logic [7:0] SIG_ONE      = 8'h01;
  localparam int         BSY_BIT      = 7;

  typedef enum logic [3:0] {
    PH_IDLE, PH_PROBE, PH_SEL0, PH_SRST, PH_WAIT0,
    PH_SEL1, PH_REG1, PH_BREATH, PH_WAIT1, PH_FIN
  } phase_t;

  typedef struct packed {
    logic             wr;
    logic [REG_W-1:0] rg;
    logic [7:0]       wd;
  } bus_op_t;
endpackage

// File: rtl/ata_span_timer.sv
module ata_span_timer #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm,
  output logic [TW-1:0] elapsed
);
  logic [TW-1:0] free_cnt;
  logic [TW-1:0] mark;

  always_ff @(posedge clk) begin
    if (rst) begin
      free_cnt <= '0;
      mark     <= '0;
    end else begin
      free_cnt <= free_cnt + TW'(1);
      if (arm) mark <= free_cnt;
    end
  end

  assign elapsed = free_cnt - mark;
endmodule

// File: rtl/ata_probe_opdec.sv
module ata_probe_opdec
  import ata_probe_pkg::*;
(
  input  phase_t     phase,
  input  logic [3:0] step,
  input  logic       dev,
  input  logic [7:0] ctl_base,
  output bus_op_t    op
);
  localparam logic [7:0] SEL0 = DEV_SEL_BASE;
  localparam logic [7:0] SEL1 = DEV_SEL_BASE | DEV1_MASK;

  logic       swap;
  logic [7:0] nval;
  logic [7:0] lval;

  always_comb begin
    swap = (step == 4'd3) || (step == 4'd4);
    nval = swap ? PAT_B : PAT_A;
    lval = swap ? PAT_A : PAT_B;
    op   = '{1'b0, REG_STAT, 8'h00};
    case (phase)
      PH_PROBE: begin
        case (step)
          4'd0:             op = '{1'b1, REG_DEV, (dev ? SEL1 : SEL0)};
          4'd1, 4'd3, 4'd5: op = '{1'b1, REG_NSECT, nval};
          4'd2, 4'd4, 4'd6: op = '{1'b1, REG_LBAL, lval};
          4'd7:             op = '{1'b0, REG_NSECT, 8'h00};
          default:          op = '{1'b0, REG_LBAL, 8'h00};
        endcase
      end
      PH_SEL0: op = '{1'b1, REG_DEV, SEL0};
      PH_SEL1: op = '{1'b1, REG_DEV, SEL1};
      PH_SRST: op = '{1'b1, REG_CTL, ((step == 4'd2) ? (ctl_base | SRST_MASK) : ctl_base)};
      PH_REG1: op = '{1'b0, ((step == 4'd0) ? REG_NSECT : REG_LBAL), 8'h00};
      PH_FIN:  op = '{1'b1, REG_DEV, ((step == 4'd1) ? SEL1 : SEL0)};
      default: ;
    endcase
  end
endmodule

// File: rtl/ata_probe_seq.sv
module ata_probe_seq
  import ata_probe_pkg::*;
#(
  parameter int TW            = 32,
  parameter int SRST_CYCLES   = 2000,
  parameter int BREATH_CYCLES = 5000000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             slave_possible,
  input  logic [7:0]       ctl_normal,
  input  logic [TW-1:0]    deadline_cycles,
  input  logic [TW-1:0]    elapsed,
  input  bus_op_t          op,
  output logic             arm,
  output phase_t           phase,
  output logic [3:0]       step,
  output logic             dev,
  output logic [7:0]       ctl_q,
  output logic             pio_req,
  output logic             pio_write,
  output logic [REG_W-1:0] pio_reg,
  output logic [7:0]       pio_wdata,
  input  logic             pio_done,
  input  logic [7:0]       pio_rdata,
  output logic             busy,
  output logic             done,
  output logic [1:0]       present,
  output logic             timeout
);
  localparam logic [TW-1:0] SRST_LEN   = TW'(SRST_CYCLES);
  localparam logic [TW-1:0] BREATH_LEN = TW'(BREATH_CYCLES);
  localparam logic [3:0]    PROBE_RD_N = 4'd7;
  localparam logic [3:0]    PROBE_LAST = 4'd8;
  localparam logic [3:0]    SRST_LAST  = 4'd4;

  logic          attempt;
  logic          slave_q;
  logic [7:0]    nsect_q;
  logic [TW-1:0] deadline_q;
  logic          in_dly;
  logic          tmr_valid;
  logic [TW-1:0] dly_len;
  logic          st_float;
  logic          st_ready;

  always_comb begin
    in_dly    = ((phase == PH_SRST) && step[0]) || (phase == PH_BREATH);
    dly_len   = (phase == PH_BREATH) ? BREATH_LEN : SRST_LEN;
    tmr_valid = !arm;
    st_float  = (pio_rdata == STAT_FLOAT);
    st_ready  = st_float || !pio_rdata[BSY_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;   step <= '0;       dev <= 1'b0;      attempt <= 1'b0;
      arm <= 1'b0;        busy <= 1'b0;     done <= 1'b0;     present <= '0;
      timeout <= 1'b0;    pio_req <= 1'b0;  pio_write <= 1'b0; pio_reg <= '0;
      pio_wdata <= '0;    nsect_q <= '0;    ctl_q <= '0;      slave_q <= 1'b0;
      deadline_q <= '0;
    end else begin
      arm  <= 1'b0;
      done <= 1'b0;
      if (phase == PH_IDLE) begin
        if (start) begin
          phase <= PH_PROBE; step <= '0; dev <= 1'b0; attempt <= 1'b0;
          busy <= 1'b1; present <= '0; timeout <= 1'b0; arm <= 1'b1;
          ctl_q <= ctl_normal; slave_q <= slave_possible; deadline_q <= deadline_cycles;
        end
      end else if (in_dly) begin
        if (tmr_valid && (elapsed >= dly_len)) begin
          arm <= 1'b1;
          if (phase == PH_BREATH) begin
            phase <= PH_REG1;
            step  <= '0;
          end else begin
            step <= step + 4'd1;
          end
        end
      end else if (!pio_req) begin
        pio_req   <= 1'b1;
        pio_write <= op.wr;
        pio_reg   <= op.rg;
        pio_wdata <= op.wd;
      end else if (pio_done) begin
        pio_req <= 1'b0;
        arm     <= 1'b1;
        case (phase)
          PH_PROBE: begin
            if (step == PROBE_RD_N) nsect_q <= pio_rdata;
            if (step == PROBE_LAST) begin
              present[dev] <= (nsect_q == PAT_A) && (pio_rdata == PAT_B);
              step <= '0;
              if (!dev && slave_q) dev <= 1'b1;
              else                 phase <= PH_SEL0;
            end else begin
              step <= step + 4'd1;
            end
          end
          PH_SEL0: begin phase <= PH_SRST; step <= '0; end
          PH_SRST: begin
            if (step == SRST_LAST) begin phase <= PH_WAIT0; step <= '0; end
            else step <= step + 4'd1;
          end
          PH_WAIT0, PH_WAIT1: begin
            if (st_ready) begin
              if (st_float) present[phase == PH_WAIT1] <= 1'b0;
              phase <= ((phase == PH_WAIT0) && present[1]) ? PH_SEL1 : PH_FIN;
              step  <= '0;
            end else if (tmr_valid && (elapsed >= deadline_q)) begin
              timeout <= 1'b1; phase <= PH_IDLE; busy <= 1'b0; done <= 1'b1;
            end else begin
              arm <= 1'b0;
            end
          end
          PH_SEL1: begin phase <= PH_REG1; step <= '0; attempt <= 1'b0; end
          PH_REG1: begin
            if (step == 4'd0) begin
              nsect_q <= pio_rdata;
              step    <= 4'd1;
            end else if ((nsect_q == SIG_ONE) && (pio_rdata == SIG_ONE)) begin
              phase <= PH_WAIT1;
            end else if (!attempt) begin
              attempt <= 1'b1;
              phase   <= PH_BREATH;
            end else begin
              phase <= PH_WAIT1;
            end
          end
          PH_FIN: begin
            if (step == 4'd0 && present[1])      step <= 4'd1;
            else if (step != 4'd2 && present[0]) step <= 4'd2;
            else begin phase <= PH_IDLE; busy <= 1'b0; done <= 1'b1; end
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    pio_req && !pio_done |=> pio_req && $stable(pio_reg) && $stable(pio_write) && $stable(pio_wdata)); // R11
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
    pio_req && pio_done |=> !pio_req); // R11
  AST_DEV_CODE: assert property (@(posedge clk) disable iff (rst)
    pio_req && pio_write && (pio_reg == REG_DEV) |-> (pio_wdata == 8'hA0) || (pio_wdata == 8'hB0)); // R2
  AST_CTL_CODE: assert property (@(posedge clk) disable iff (rst)
    pio_req && pio_write && (pio_reg == REG_CTL) |-> ((pio_wdata & ~SRST_MASK) == (ctl_q & ~SRST_MASK))); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R12
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !pio_req); // R12
  AST_TIMEOUT_END: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout) |-> done && !busy); // R8
  AST_PRESENT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !busy |=> busy || $stable(present)); // R4
endmodule

// File: rtl/ata_probe_reset.sv
module ata_probe_reset
  import ata_probe_pkg::*;
#(
  parameter int TW            = 32,
  parameter int SRST_CYCLES   = 2000,
  parameter int BREATH_CYCLES = 5000000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          slave_possible,
  input  logic [7:0]    ctl_normal,
  input  logic [TW-1:0] deadline_cycles,
  output logic          pio_req,
  output logic          pio_write,
  output logic [3:0]    pio_reg,
  output logic [7:0]    pio_wdata,
  input  logic          pio_done,
  input  logic [7:0]    pio_rdata,
  output logic          busy,
  output logic          done,
  output logic [1:0]    present,
  output logic          timeout
);
  logic          arm;
  logic [TW-1:0] elapsed;
  phase_t        phase;
  logic [3:0]    step;
  logic          dev;
  logic [7:0]    ctl_q;
  bus_op_t       op;

  ata_span_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst(rst), .arm(arm), .elapsed(elapsed)
  );

  ata_probe_opdec u_opdec (
    .phase(phase), .step(step), .dev(dev), .ctl_base(ctl_q), .op(op)
  );

  ata_probe_seq #(
    .TW(TW), .SRST_CYCLES(SRST_CYCLES), .BREATH_CYCLES(BREATH_CYCLES)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start), .slave_possible(slave_possible),
    .ctl_normal(ctl_normal), .deadline_cycles(deadline_cycles),
    .elapsed(elapsed), .op(op), .arm(arm), .phase(phase), .step(step),
    .dev(dev), .ctl_q(ctl_q), .pio_req(pio_req), .pio_write(pio_write),
    .pio_reg(pio_reg), .pio_wdata(pio_wdata), .pio_done(pio_done),
    .pio_rdata(pio_rdata), .busy(busy), .done(done), .present(present),
    .timeout(timeout)
  );
endmodule

// File: tb/sim_ata_probe_reset.sv
`timescale 1ns/1ps
module sim_ata_probe_reset;
  localparam int TW = 32, SRST = 20, BREATH = 60, DEADLINE = 40;
  localparam bit [3:0] C_NS = 4'h2, C_LB = 4'h3, C_DV = 4'h6, C_ST = 4'h7, C_CT = 4'hE;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, slave_possible = 1'b0;
  logic [7:0] ctl_normal = 8'h00;
  logic [TW-1:0] deadline_cycles = TW'(DEADLINE);
  logic pio_req, pio_write, pio_done, busy, done, timeout;
  logic [3:0] pio_reg;
  logic [7:0] pio_wdata, pio_rdata;
  logic [1:0] present;

  ata_probe_reset #(.TW(TW), .SRST_CYCLES(SRST), .BREATH_CYCLES(BREATH)) u0 (
    .clk(clk), .rst(rst), .start(start), .slave_possible(slave_possible),
    .ctl_normal(ctl_normal), .deadline_cycles(deadline_cycles),
    .pio_req(pio_req), .pio_write(pio_write), .pio_reg(pio_reg),
    .pio_wdata(pio_wdata), .pio_done(pio_done), .pio_rdata(pio_rdata),
    .busy(busy), .done(done), .present(present), .timeout(timeout)
  );

  always #2.5 clk = ~clk;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    bit wr; bit [3:0] rg; bit [7:0] wd; bit [7:0] rd; int gap; bit sticky; int rq;
  } item_t;
  item_t expq[$];
  int nchk = 0, nfail = 0, last_op_cyc = 0, first_stat_cyc = -1;

  task automatic check(input bit ok, input int rq, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL R%0d %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic push(input bit wr, input bit [3:0] rg, input bit [7:0] wd, input bit [7:0] rd,
                      input int gap, input int rq, input bit sticky = 1'b0);
    item_t it;
    it.wr = wr; it.rg = rg; it.wd = wd; it.rd = rd; it.gap = gap; it.sticky = sticky; it.rq = rq;
    expq.push_back(it);
  endtask

  // R3: select, six alternating pattern writes, two readbacks
  task automatic push_probe(input bit d, input bit [7:0] rn, input bit [7:0] rl);
    push(1, C_DV, d ? 8'hB0 : 8'hA0, 0, 0, 2);
    push(1, C_NS, 8'h55, 0, 0, 3); push(1, C_LB, 8'hAA, 0, 0, 3);
    push(1, C_NS, 8'hAA, 0, 0, 3); push(1, C_LB, 8'h55, 0, 0, 3);
    push(1, C_NS, 8'h55, 0, 0, 3); push(1, C_LB, 8'hAA, 0, 0, 3);
    push(0, C_NS, 0, rn, 0, 3);    push(0, C_LB, 0, rl, 0, 4);
  endtask

  // R5 reselect of device 0, then R6 reset pulse with spacing
  task automatic push_srst(input bit [7:0] c);
    push(1, C_DV, 8'hA0, 0, 0, 5);
    push(1, C_CT, c, 0, 0, 6);
    push(1, C_CT, c | 8'h04, 0, SRST, 6);
    push(1, C_CT, c, 0, SRST, 6);
  endtask

  // Monitor: models the PIO engine and compares each operation
  initial begin
    pio_done = 1'b0; pio_rdata = 8'h00;
    forever begin
      @(negedge clk);
      if (pio_req) begin
        item_t it;
        bit [7:0] rd;
        rd = 8'h00;
        if (expq.size() == 0) begin
          check(1'b0, 11, "unexpected bus op {wr,reg,data}", {pio_write, pio_reg, pio_wdata}, 0);
        end else begin
          it = expq[0];
          if (!it.sticky) expq.delete(0);
          check(pio_write == it.wr && pio_reg == it.rg && (!it.wr || pio_wdata == it.wd), it.rq,
                "bus op {wr,reg,data}", {pio_write, pio_reg, pio_wdata}, {it.wr, it.rg, it.wd});
          if (it.gap > 0) check(cyc - last_op_cyc >= it.gap, it.rq, "min gap cycles", cyc - last_op_cyc, it.gap);
          if (it.rg == C_ST && first_stat_cyc < 0) first_stat_cyc = cyc;
          rd = it.rd;
        end
        last_op_cyc = cyc;
        @(negedge clk); @(negedge clk);
        pio_rdata = rd; pio_done = 1'b1;
        @(negedge clk);
        pio_done = 1'b0;
      end
    end
  end

  task automatic run(input bit slave, input bit [7:0] ctl, input bit [1:0] exp_pres,
                     input bit exp_to);
    int w;
    int span;
    @(negedge clk);
    slave_possible = slave; ctl_normal = ctl; first_stat_cyc = -1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (30) @(negedge clk);
    // R12: a second start and changed inputs mid-run must be ignored
    start = 1'b1; slave_possible = ~slave; ctl_normal = 8'hFF;
    @(negedge clk); start = 1'b0;
    w = 0;
    while (!done && w < 20000) begin @(negedge clk); w++; end
    check(done, 12, "done pulse seen", done, 1);
    check(present == exp_pres, 4, "presence mask", present, exp_pres);
    check(timeout == exp_to, 8, "timeout flag", timeout, exp_to);
    check(!busy, 12, "busy low at done", busy, 0);
    if (exp_to) begin
      span = cyc - first_stat_cyc;
      check(span >= DEADLINE - 2 && span <= DEADLINE + 12, 8, "deadline span", span, DEADLINE);
    end
    @(negedge clk);
    check(!done, 12, "done one cycle", done, 0);
    repeat (8) @(negedge clk);
    check(!pio_req, 8, "no op after run end", pio_req, 0);
    check(expq.size() == 0 || (exp_to && expq.size() == 1 && expq[0].sticky), 10,
          "ops left unissued", expq.size(), 0);
    expq.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!busy && !done && !timeout && !pio_req && present == 2'b00, 1, "reset outputs",
          {busy, done, timeout, pio_req, present}, 0);

    // S1: both devices, ready at once, device-1 check passes first time (R9, R10)
    push_probe(0, 8'h55, 8'hAA); push_probe(1, 8'h55, 8'hAA);
    push_srst(8'h00);
    push(0, C_ST, 0, 8'h50, 0, 7);
    push(1, C_DV, 8'hB0, 0, 0, 9); push(0, C_NS, 0, 8'h01, 0, 9); push(0, C_LB, 0, 8'h01, 0, 9);
    push(0, C_ST, 0, 8'h00, 0, 7);
    push(1, C_DV, 8'hA0, 0, 0, 10); push(1, C_DV, 8'hB0, 0, 0, 10); push(1, C_DV, 8'hA0, 0, 0, 10);
    run(1'b1, 8'h00, 2'b11, 1'b0);

    // S2: no slave probing (R5), busy twice then ready (R7)
    push_probe(0, 8'h55, 8'hAA);
    push_srst(8'h02);
    push(0, C_ST, 0, 8'h80, 0, 7); push(0, C_ST, 0, 8'h80, 0, 7); push(0, C_ST, 0, 8'h50, 0, 7);
    push(1, C_DV, 8'hA0, 0, 0, 10); push(1, C_DV, 8'hA0, 0, 0, 10);
    run(1'b0, 8'h02, 2'b01, 1'b0);

    // S3: master absent, slave present, second register attempt after pause (R9)
    push_probe(0, 8'hFF, 8'hFF); push_probe(1, 8'h55, 8'hAA);
    push_srst(8'h00);
    push(0, C_ST, 0, 8'h00, 0, 7);
    push(1, C_DV, 8'hB0, 0, 0, 9); push(0, C_NS, 0, 8'h00, 0, 9); push(0, C_LB, 0, 8'h00, 0, 9);
    push(0, C_NS, 0, 8'h01, BREATH, 9); push(0, C_LB, 0, 8'h01, 0, 9);
    push(0, C_ST, 0, 8'h50, 0, 7);
    push(1, C_DV, 8'hA0, 0, 0, 10); push(1, C_DV, 8'hB0, 0, 0, 10);
    run(1'b1, 8'h00, 2'b10, 1'b0);

    // S4: both attempts fail, no third; slave status floats 0xFF (R7, R9)
    push_probe(0, 8'h55, 8'hAA); push_probe(1, 8'h55, 8'hAA);
    push_srst(8'h00);
    push(0, C_ST, 0, 8'h50, 0, 7);
    push(1, C_DV, 8'hB0, 0, 0, 9); push(0, C_NS, 0, 8'h01, 0, 9); push(0, C_LB, 0, 8'h00, 0, 9);
    push(0, C_NS, 0, 8'h01, BREATH, 9); push(0, C_LB, 0, 8'h00, 0, 9);
    push(0, C_ST, 0, 8'hFF, 0, 7);
    push(1, C_DV, 8'hA0, 0, 0, 10); push(1, C_DV, 8'hA0, 0, 0, 10);
    run(1'b1, 8'h00, 2'b01, 1'b0);

    // S5: half-matching readback is absent (R4); busy forever gives timeout (R8)
    push_probe(0, 8'h55, 8'h55);
    push_srst(8'h00);
    push(0, C_ST, 0, 8'h80, 0, 8, 1'b1);
    run(1'b0, 8'h00, 2'b00, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule